// File: doc/BRIEF.md
# Registered Bidirectional Lane Transceiver

This block moves a group of data lanes in both directions between a single-ended A side and a bus B side. The bus side is modelled digitally. Each incoming bus lane has a data level and a valid flag, and each outgoing bus lane has a data level. One drive flag covers the whole outgoing bus. Each direction has its own storage element. A two-bit mode code selects how that element behaves: a pass-through buffer, an edge-triggered register clocked by the direction's own strobe, or a transparent latch gated by that strobe.

The two elements can be chained in either direction, which supports diagnostics:
- A-side loopback sends the A input through both elements back to the A output.
- Bus loopback captures bus data in the B-to-A latch and sends it back onto the bus through the A-to-B latch.

Each side has its own output enable. A receiver enable decides whether bus data reaches the B-to-A path. Both storage elements keep working while their outputs are released. All lanes share the same controls, and the strobes are sampled on the block clock.

Top module: `bidir_lane_xcvr`

## Requirements
- R1: With a mode code of 00 (buffer), an element's output equals its input in the same cycle, with no clock edge needed.
- R2: With mode code 01 (register), an element loads its input at the first clock edge where its own strobe is seen high after having been low. The output shows the loaded value from the following cycle and holds it until the next such rise. The two directions use independent strobes.
- R3: With mode code 10 (latch), the output follows the input while the strobe is high. After the strobe goes low, the output holds the value that was present at the last clock edge with the strobe high.
- R4: When both mode codes are 11, the B-to-A element latches receiver data and the A-to-B element latches the B-to-A output onto the bus. When only one code is 11, that element acts as a plain latch on its normal input.
- R5: With `loop_i` high and bus loopback not active, the B-to-A element takes the A-to-B output in place of receiver data. RA therefore reproduces DA through whichever modes are configured.
- R6: With `a_oe_i` low, `a_data_o` reads all zeros and `a_drive_o` is low. With `b_oe_i` low, `bus_data_o` reads all zeros and `bus_drive_o` is low. When both are low, the sides are isolated.
- R7: Storage elements load and hold data while their side's output is disabled. Re-enabling the output shows the stored value.
- R8: With `rx_off_i` high, the receiver passes all zeros to the B-to-A path, whatever the bus carries.
- R9: A bus lane whose valid flag is low reads as 0 at the receiver output (fail-safe).
- R10: Reset clears both storage elements, so that register-mode and latch-mode outputs with the strobe low read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; strobes are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ab_mode_i | input | 2 | A-to-B element mode code |
| ba_mode_i | input | 2 | B-to-A element mode code |
| ab_le_i | input | 1 | A-to-B register strobe / latch enable |
| ba_le_i | input | 1 | B-to-A register strobe / latch enable |
| a_oe_i | input | 1 | A-side output enable |
| b_oe_i | input | 1 | Bus-side output enable |
| rx_off_i | input | 1 | High blocks bus data from the B-to-A path |
| loop_i | input | 1 | A-side loopback select |
| a_data_i | input | LANES | A-side input data (DA) |
| a_data_o | output | LANES | A-side output data (RA) |
| a_drive_o | output | 1 | A-side outputs driven |
| bus_data_i | input | LANES | Incoming bus levels |
| bus_valid_i | input | LANES | Per-lane flag, high when the bus lane is actively driven |
| bus_data_o | output | LANES | Outgoing bus levels |
| bus_drive_o | output | 1 | Bus outputs driven |

## Verification
The bench builds the block with LANES at its default of 8, so each stimulus is one byte. Alternating and all-ones patterns then reach every lane in both directions. With eight lanes, a partial valid mask such as 0x0F shows the fail-safe on half the lanes while the other half still passes data. The same width also lets the chained loopback paths be checked with distinct patterns on DA and on the bus, so a wrong path selection shows up as the wrong byte.

// File: rtl/bidir_lane_xcvr_pkg.sv
package bidir_lane_xcvr_pkg;
  typedef enum logic [1:0] {
    MODE_BUF  = 2'b00,
    MODE_REG  = 2'b01,
    MODE_LAT  = 2'b10,
    MODE_LOOP = 2'b11
  } xcvr_mode_e;
endpackage

// File: rtl/xcvr_rx_gate.sv
module xcvr_rx_gate #(
  parameter int unsigned LANES = 8
) (
  input  logic             rx_off_i,
  input  logic [LANES-1:0] bus_data_i,
  input  logic [LANES-1:0] bus_valid_i,
  output logic [LANES-1:0] rx_data_o
);
  // undriven lane resolves low; disabled receiver resolves low
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign rx_data_o[i] = !rx_off_i && bus_valid_i[i] && bus_data_i[i];
  end
endmodule

// File: rtl/xcvr_stage.sv
module xcvr_stage
  import bidir_lane_xcvr_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  xcvr_mode_e       mode_i,
  input  logic             le_i,
  input  logic [LANES-1:0] d_i,
  output logic [LANES-1:0] q_o,
  output logic [LANES-1:0] held_o
);
  logic             le_q;
  logic [LANES-1:0] store_q;
  logic             load;

  always_comb begin
    unique case (mode_i)
      MODE_BUF: load = 1'b0;
      MODE_REG: load = le_i && !le_q;
      default:  load = le_i;         // latch and loop codes
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      le_q    <= 1'b0;
      store_q <= '0;
    end else begin
      le_q <= le_i;
      if (load) store_q <= d_i;
    end
  end

  always_comb begin
    unique case (mode_i)
      MODE_BUF: q_o = d_i;
      MODE_REG: q_o = store_q;
      default:  q_o = le_i ? d_i : store_q;
    endcase
  end

  assign held_o = store_q;

  // R2
  reg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_REG && !(le_i && !le_q)) |=> (mode_i != MODE_REG || $stable(q_o)));

  // R3
  lat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1] && le_i) |=> (!mode_i[1] || le_i || q_o == $past(d_i)));
endmodule

// File: rtl/bidir_lane_xcvr.sv
module bidir_lane_xcvr
  import bidir_lane_xcvr_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       ab_mode_i,
  input  logic [1:0]       ba_mode_i,
  input  logic             ab_le_i,
  input  logic             ba_le_i,
  input  logic             a_oe_i,
  input  logic             b_oe_i,
  input  logic             rx_off_i,
  input  logic             loop_i,
  input  logic [LANES-1:0] a_data_i,
  output logic [LANES-1:0] a_data_o,
  output logic             a_drive_o,
  input  logic [LANES-1:0] bus_data_i,
  input  logic [LANES-1:0] bus_valid_i,
  output logic [LANES-1:0] bus_data_o,
  output logic             bus_drive_o
);
  xcvr_mode_e       ab_mode, ba_mode;
  logic             bus_loop;
  logic [LANES-1:0] rx_data;
  logic [LANES-1:0] ab_d, ab_q, ab_held;
  logic [LANES-1:0] ba_d, ba_q, ba_held;

  assign ab_mode  = xcvr_mode_e'(ab_mode_i);
  assign ba_mode  = xcvr_mode_e'(ba_mode_i);
  assign bus_loop = (ab_mode == MODE_LOOP) && (ba_mode == MODE_LOOP);

  xcvr_rx_gate #(.LANES(LANES)) u_rx (
    .rx_off_i   (rx_off_i),
    .bus_data_i (bus_data_i),
    .bus_valid_i(bus_valid_i),
    .rx_data_o  (rx_data)
  );

  // bus loopback: rebuild the B-to-A latch output from its store, no comb cycle
  assign ab_d = bus_loop ? (ba_le_i ? rx_data : ba_held) : a_data_i;
  assign ba_d = (loop_i && !bus_loop) ? ab_q : rx_data;

  xcvr_stage #(.LANES(LANES)) u_ab (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mode_i(ab_mode),
    .le_i  (ab_le_i),
    .d_i   (ab_d),
    .q_o   (ab_q),
    .held_o(ab_held)
  );

  xcvr_stage #(.LANES(LANES)) u_ba (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mode_i(ba_mode),
    .le_i  (ba_le_i),
    .d_i   (ba_d),
    .q_o   (ba_q),
    .held_o(ba_held)
  );

  assign a_data_o    = a_oe_i ? ba_q : '0;
  assign a_drive_o   = a_oe_i;
  assign bus_data_o  = b_oe_i ? ab_q : '0;
  assign bus_drive_o = b_oe_i;

  // R5
  a_loop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_i && ab_mode == MODE_BUF && ba_mode == MODE_BUF) |-> ba_q == a_data_i);

  // R8
  rx_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_off_i && !loop_i && ba_mode == MODE_BUF) |-> ba_q == '0);

  // R9
  fail_safe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!loop_i && ba_mode == MODE_BUF) |-> (ba_q & ~bus_valid_i) == '0);

  // R4
  bus_loop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_loop && ab_le_i) |-> ab_q == ba_q);
endmodule

// File: tb/bidir_lane_xcvr_test.sv
module bidir_lane_xcvr_test;
  localparam int LANES = 8;
  localparam int NVEC  = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] ab_mode, ba_mode;
  logic ab_le, ba_le, a_oe, b_oe, rx_off, loop_en;
  logic [LANES-1:0] a_din, bus_din, bus_val;
  logic [LANES-1:0] a_dout, bus_dout;
  logic a_drv, bus_drv;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  bidir_lane_xcvr #(.LANES(LANES)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .ab_mode_i(ab_mode), .ba_mode_i(ba_mode),
    .ab_le_i(ab_le), .ba_le_i(ba_le),
    .a_oe_i(a_oe), .b_oe_i(b_oe), .rx_off_i(rx_off), .loop_i(loop_en),
    .a_data_i(a_din), .a_data_o(a_dout), .a_drive_o(a_drv),
    .bus_data_i(bus_din), .bus_valid_i(bus_val),
    .bus_data_o(bus_dout), .bus_drive_o(bus_drv)
  );

  task automatic chk(input string tag, input logic [LANES-1:0] act, input logic [LANES-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // {a_oe, b_oe, rx_off, loop, valid, da, bus_in, exp_ra, exp_bus}; all modes buffer
  localparam logic [43:0] VEC [NVEC] = '{
    {4'b1100, 8'hFF, 8'hA5, 8'h3C, 8'h3C, 8'hA5},  // R1
    {4'b1100, 8'h0F, 8'h5A, 8'hFF, 8'h0F, 8'h5A},  // R9 partial
    {4'b1110, 8'hFF, 8'h11, 8'hFF, 8'h00, 8'h11},  // R8
    {4'b1101, 8'hFF, 8'hC3, 8'hFF, 8'hC3, 8'hC3},  // R5 buffer loop
    {4'b0100, 8'hFF, 8'h77, 8'h88, 8'h00, 8'h77},  // R6 A off
    {4'b1000, 8'hFF, 8'h77, 8'h88, 8'h88, 8'h00},  // R6 B off
    {4'b0000, 8'hFF, 8'h77, 8'h88, 8'h00, 8'h00},  // R6 isolation
    {4'b1100, 8'h00, 8'h01, 8'hFF, 8'h00, 8'h01}   // R9 all open
  };

  initial begin
    ab_mode = 2'b01; ba_mode = 2'b01; ab_le = 0; ba_le = 0;
    a_oe = 1; b_oe = 1; rx_off = 0; loop_en = 0;
    a_din = 8'hFF; bus_din = 8'hFF; bus_val = 8'hFF;
    #12;
    chk("R10 reset ra", a_dout, 8'h00);
    chk("R10 reset bus", bus_dout, 8'h00);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk("R10 after release ra", a_dout, 8'h00);
    chk("R10 after release bus", bus_dout, 8'h00);

    // table walk, buffer mode
    ab_mode = 2'b00; ba_mode = 2'b00;
    for (int i = 0; i < NVEC; i++) begin
      {a_oe, b_oe, rx_off, loop_en} = VEC[i][43:40];
      bus_val = VEC[i][39:32];
      a_din   = VEC[i][31:24];
      bus_din = VEC[i][23:16];
      #2;
      chk($sformatf("R1/R5/R6/R8/R9 vec %0d ra", i), a_dout, VEC[i][15:8]);
      chk($sformatf("R1/R5/R6/R8/R9 vec %0d bus", i), bus_dout, VEC[i][7:0]);
      chk($sformatf("R6 vec %0d drive", i), {6'b0, a_drv, bus_drv}, {6'b0, a_oe, b_oe});
      @(negedge clk);
    end

    // R2 register mode, independent strobes
    a_oe = 1; b_oe = 1; rx_off = 0; loop_en = 0; bus_val = 8'hFF;
    ab_mode = 2'b01; ba_mode = 2'b01; bus_din = 8'h96; a_din = 8'h5A;
    @(negedge clk);
    ab_le = 1;
    @(negedge clk);
    chk("R2 ab load", bus_dout, 8'h5A);
    chk("R2 ba untouched", a_dout, 8'h00);
    a_din = 8'h33;
    @(negedge clk);
    chk("R2 strobe held high", bus_dout, 8'h5A);
    ab_le = 0; ba_le = 1;
    @(negedge clk);
    chk("R2 ba load", a_dout, 8'h96);
    chk("R2 ab holds", bus_dout, 8'h5A);
    ba_le = 0;

    // R3 latch
    ab_mode = 2'b10; ab_le = 1; a_din = 8'hC0;
    #2 chk("R3 transparent 1", bus_dout, 8'hC0);
    a_din = 8'h0E;
    #2 chk("R3 transparent 2", bus_dout, 8'h0E);
    @(negedge clk);
    ab_le = 0; a_din = 8'hF1;
    #2 chk("R3 hold", bus_dout, 8'h0E);

    // R7 storage while disabled
    @(negedge clk);
    b_oe = 0; ab_le = 1; a_din = 8'h9D;
    @(negedge clk);
    ab_le = 0; a_din = 8'h00;
    #2 chk("R6 bus released", {bus_dout[6:0], bus_drv}, 8'h00);
    @(negedge clk);
    b_oe = 1;
    #2 chk("R7 latch kept while off", bus_dout, 8'h9D);
    a_oe = 0; ba_mode = 2'b01; bus_din = 8'h3E;
    @(negedge clk);
    ba_le = 1;
    @(negedge clk);
    ba_le = 0;
    #2 chk("R6 ra released", a_dout, 8'h00);
    a_oe = 1;
    #2 chk("R7 register kept while off", a_dout, 8'h3E);

    // R5 loop through both registers
    @(negedge clk);
    ab_mode = 2'b01; ba_mode = 2'b01; loop_en = 1; bus_din = 8'hFF; a_din = 8'h6B;
    @(negedge clk);
    ab_le = 1;
    @(negedge clk);
    ab_le = 0; ba_le = 1;
    @(negedge clk);
    ba_le = 0;
    #2 chk("R5 register loop ra", a_dout, 8'h6B);
    chk("R5 register loop bus", bus_dout, 8'h6B);
    // R5 loop through both latches
    @(negedge clk);
    ab_mode = 2'b10; ba_mode = 2'b10; ab_le = 1; ba_le = 1; a_din = 8'hE1;
    #2 chk("R5 latch loop ra", a_dout, 8'hE1);

    // R4 bus loopback
    @(negedge clk);
    loop_en = 0; ab_mode = 2'b11; ba_mode = 2'b11; bus_din = 8'h4D; a_din = 8'h00;
    #2 chk("R4 bus echo", bus_dout, 8'h4D);
    chk("R4 ra sees bus", a_dout, 8'h4D);
    @(negedge clk);
    ba_le = 0; bus_din = 8'h00;
    #2 chk("R4 echo held", bus_dout, 8'h4D);
    // R4 single code 11 is a plain latch
    @(negedge clk);
    ba_mode = 2'b00; ab_le = 1; a_din = 8'h21; bus_din = 8'h5C;
    #2 chk("R4 single 11 transparent", bus_dout, 8'h21);
    chk("R4 single 11 ra buffer", a_dout, 8'h5C);
    @(negedge clk);
    ab_le = 0; a_din = 8'h22;
    #2 chk("R4 single 11 holds", bus_dout, 8'h21);

    // R10 reset mid-run clears storage
    ab_mode = 2'b10; ba_mode = 2'b10; ab_le = 0; ba_le = 0;
    @(negedge clk);
    rst_ni = 0;
    #2 chk("R10 mid reset bus", bus_dout, 8'h00);
    chk("R10 mid reset ra", a_dout, 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule